// File: doc/BRIEF.md
# Configurable GPIO Port with Function Mux

This block is an eight-pin general-purpose I/O port. Each pin has its own register bits for direction, output value, pull enable, a two-bit function select, interrupt edge polarity, interrupt enable and interrupt flag. For each pin, the direction bit and the function code together choose the pin's role. A pin can be plain I/O, or it can drive one of three peripheral outputs: a serial-interface line, a clock output or a timer output. A pin can also pass its pad value to a timer capture input. An interrupt vector register reports the lowest-numbered enabled pending pin and acknowledges it when read.

Four pins can also carry a debug port: a clock input, a data input, a data output and a mode-select input. When the debug strap is high, the debug function takes those pins away from the port registers. The three debug input lines then carry the pad values. When the strap is low, those three lines read as 1. Every pin comes out of reset in its own state, so the debug pins start with pull-ups enabled and a debug function selected.

Software reaches the registers through a simple single-cycle bus. A write is taken on the clock edge. Read data is combinational from the address.

Top module: `gpio_port`

## Requirements
- R1: After reset, the registers read: output 0xB0, direction 0x00, pull 0xB0, select-low 0xF0, select-high 0xF0, flags 0x00. Every pad is undriven. Pull-ups are active on pins 4, 5 and 7. Register addresses are: 0 input, 1 output, 2 direction, 3 pull, 4 select-low, 5 select-high, 6 edge, 7 enable, 8 flag, 9 vector.
- R2: With function code {select-high, select-low} = 00, a pin drives `pad_out` from its output bit when its direction bit is 1. It is undriven when the direction bit is 0.
- R3: With direction 1, code 01 drives the pin from `ser_out_i`, code 10 drives it from `clk_out_i` and code 11 drives it from `tmr_out_i`.
- R4: With direction 0 and a nonzero code, `cap_in_o` follows the pad input. In every other case `cap_in_o` is 0.
- R5: An undriven pin with its pull bit set has its pull enabled. The pull goes up when the output bit is 1 and down when it is 0. A driven pin never has its pull enabled.
- R6: While `dbg_mode` is 1, the debug hardware takes over the debug pins regardless of the port registers. Pin 6 drives `dbg_drive_val`. Pins 4, 5 and 7 are undriven with pull-ups.
- R7: While `dbg_mode` is 0, `dbg_clk_o`, `dbg_din_o` and `dbg_sel_o` read as 1. While it is 1, they follow pads 4, 5 and 7.
- R8: A flag bit sets on a rising pad edge when the pin's edge bit is 0, and on a falling edge when it is 1. An edge of the other polarity leaves the flag unchanged.
- R9: Reading the vector register returns 2×(index+1) for the lowest-numbered pin whose flag and enable are both set, and clears only that flag. It returns 0 when no such pin exists.
- R10: `irq` is 1 exactly when some pin has both its flag and its enable set.
- R11: The input register reads the current pad inputs.
- R12: Software writes to the flag register replace the flags, so writing 0 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up clear) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on vector read) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | N_PINS | Write data |
| reg_rdata | output | N_PINS | Read data |
| pad_in | input | N_PINS | Pad input values |
| pad_out | output | N_PINS | Pad output values |
| pad_oe | output | N_PINS | Pad output enables |
| pad_pull_en | output | N_PINS | Pull resistor enables |
| pad_pull_up | output | N_PINS | Pull direction, 1 = up |
| ser_out_i | input | N_PINS | Serial-interface output per pin |
| clk_out_i | input | N_PINS | Clock output per pin |
| tmr_out_i | input | N_PINS | Timer output per pin |
| cap_in_o | output | N_PINS | Timer capture input per pin |
| dbg_mode | input | 1 | Debug-mode strap |
| dbg_drive_val | input | 1 | Debug data-out value |
| dbg_clk_o | output | 1 | Debug clock input |
| dbg_din_o | output | 1 | Debug data input |
| dbg_sel_o | output | 1 | Debug mode-select input |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with its default parameters: eight pins, the reset images 0xB0 and 0xF0, and the debug pins at indices 4 to 7. With these values, the per-pin reset values and the debug takeover of the upper nibble can be checked against a lower nibble that stays under register control in the same cycle. Eight pins produce vector codes from 2 to 16. The bench uses pins 3 and 5 to check the order of acknowledgement, and it checks the return to 0 after both flags are acknowledged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [3:0] {
        REG_IN   = 4'd0,
        REG_OUT  = 4'd1,
        REG_DIR  = 4'd2,
        REG_PULL = 4'd3,
        REG_SEL0 = 4'd4,
        REG_SEL1 = 4'd5,
        REG_EDGE = 4'd6,
        REG_IEN  = 4'd7,
        REG_FLAG = 4'd8,
        REG_VEC  = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        FN_GPIO   = 2'b00,
        FN_SERIAL = 2'b01,
        FN_CLOCK  = 2'b10,
        FN_TIMER  = 2'b11
    } pin_fn_e;

endpackage

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
(
    input  logic       dir_bit,
    input  logic       out_bit,
    input  logic       pull_bit,
    input  logic [1:0] fn_sel,
    input  logic       ser_val,
    input  logic       clk_val,
    input  logic       tmr_val,
    input  logic       dbg_act,
    input  logic       dbg_drive,
    input  logic       dbg_sense,
    input  logic       dbg_val,
    input  logic       pad_val,
    output logic       pad_drv,
    output logic       pad_en,
    output logic       pull_en,
    output logic       pull_up,
    output logic       cap_val
);

    always_comb begin
        pad_drv = out_bit;
        pad_en  = 1'b0;
        cap_val = 1'b0;
        if (dbg_act && dbg_drive) begin
            pad_drv = dbg_val;
            pad_en  = 1'b1;
        end else if (dbg_act && dbg_sense) begin
            pad_en  = 1'b0;
        end else begin
            case (pin_fn_e'(fn_sel))
                FN_GPIO: begin
                    pad_en = dir_bit;
                end
                FN_SERIAL: begin
                    pad_drv = ser_val;
                    pad_en  = dir_bit;
                    cap_val = ~dir_bit & pad_val;
                end
                FN_CLOCK: begin
                    pad_drv = clk_val;
                    pad_en  = dir_bit;
                    cap_val = ~dir_bit & pad_val;
                end
                default: begin
                    pad_drv = tmr_val;
                    pad_en  = dir_bit;
                    cap_val = ~dir_bit & pad_val;
                end
            endcase
        end

        if (dbg_act && dbg_sense) begin
            pull_en = 1'b1;
            pull_up = 1'b1;
        end else begin
            pull_en = pull_bit & ~pad_en;
            pull_up = out_bit & pull_bit & ~pad_en;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int N_PINS = 8,
    parameter int VEC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] edge_sel,
    input  logic [N_PINS-1:0] ien,
    input  logic              sw_wr,
    input  logic [N_PINS-1:0] sw_data,
    input  logic              vec_rd,
    output logic [N_PINS-1:0] flags,
    output logic [VEC_W-1:0]  vec_code,
    output logic              irq
);

    localparam int IW = (N_PINS > 1) ? $clog2(N_PINS) : 1;

    typedef struct packed {
        logic [N_PINS-1:0] last;
        logic              armed;
        logic [N_PINS-1:0] flag;
    } irq_state_t;

    irq_state_t st_d, st_q;

    logic [N_PINS-1:0] rise, fall, hit, pend;
    logic              found;
    logic [IW-1:0]     idx;

    always_comb begin
        rise  = pad_in & ~st_q.last;
        fall  = ~pad_in & st_q.last;
        hit   = st_q.armed ? ((rise & ~edge_sel) | (fall & edge_sel)) : '0;
        pend  = st_q.flag & ien;
        found = 1'b0;
        idx   = '0;
        for (int i = N_PINS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end

        st_d       = st_q;
        st_d.last  = pad_in;
        st_d.armed = 1'b1;
        if (sw_wr) begin
            st_d.flag = sw_data;
        end
        if (vec_rd && found) begin
            st_d.flag[idx] = 1'b0;
        end
        st_d.flag = st_d.flag | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags    = st_q.flag;
    assign vec_code = found ? VEC_W'(2 * (int'(idx) + 1)) : '0;
    assign irq      = |pend;

    // R8: a flag may only newly appear where an edge was seen or software wrote
    a_r8_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> ((st_q.flag & ~$past(st_q.flag) & ~$past(hit)) == '0));

    // R9: a vector read with a pending pin and no new edge removes exactly one flag
    a_r9_vec_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && found && !sw_wr && (hit == '0)) |=>
            ($countones(st_q.flag) == $past($countones(st_q.flag)) - 1));

    // R9: a vector read with nothing pending leaves the flags alone apart from new edges
    a_r9_vec_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !found && !sw_wr) |=> ((st_q.flag & ~$past(hit)) == $past(st_q.flag)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int                N_PINS       = 8,
    parameter logic [N_PINS-1:0] RST_OUT      = 'hB0,
    parameter logic [N_PINS-1:0] RST_DIR      = 'h00,
    parameter logic [N_PINS-1:0] RST_PULL     = 'hB0,
    parameter logic [N_PINS-1:0] RST_SEL0     = 'hF0,
    parameter logic [N_PINS-1:0] RST_SEL1     = 'hF0,
    parameter int                DBG_CLK_PIN  = 4,
    parameter int                DBG_DIN_PIN  = 5,
    parameter int                DBG_DOUT_PIN = 6,
    parameter int                DBG_SEL_PIN  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [N_PINS-1:0] reg_wdata,
    output logic [N_PINS-1:0] reg_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pull_en,
    output logic [N_PINS-1:0] pad_pull_up,
    input  logic [N_PINS-1:0] ser_out_i,
    input  logic [N_PINS-1:0] clk_out_i,
    input  logic [N_PINS-1:0] tmr_out_i,
    output logic [N_PINS-1:0] cap_in_o,
    input  logic              dbg_mode,
    input  logic              dbg_drive_val,
    output logic              dbg_clk_o,
    output logic              dbg_din_o,
    output logic              dbg_sel_o,
    output logic              irq
);

    localparam int VEC_W = $clog2(2 * N_PINS + 1);
    localparam logic [N_PINS-1:0] DBG_SENSE_MASK = (N_PINS'(1) << DBG_CLK_PIN)
                                                 | (N_PINS'(1) << DBG_DIN_PIN)
                                                 | (N_PINS'(1) << DBG_SEL_PIN);
    localparam logic [N_PINS-1:0] DBG_DRIVE_MASK = N_PINS'(1) << DBG_DOUT_PIN;

    typedef struct packed {
        logic [N_PINS-1:0] out;
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] pull;
        logic [N_PINS-1:0] sel0;
        logic [N_PINS-1:0] sel1;
        logic [N_PINS-1:0] edge_sel;
        logic [N_PINS-1:0] ien;
    } port_regs_t;

    port_regs_t regs_d, regs_q;

    logic              flag_wr;
    logic              vec_rd;
    logic [N_PINS-1:0] flags;
    logic [VEC_W-1:0]  vec_code;

    always_comb begin
        regs_d  = regs_q;
        flag_wr = 1'b0;
        vec_rd  = reg_rd && (reg_addr == REG_VEC);
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                REG_OUT:  regs_d.out      = reg_wdata;
                REG_DIR:  regs_d.dir      = reg_wdata;
                REG_PULL: regs_d.pull     = reg_wdata;
                REG_SEL0: regs_d.sel0     = reg_wdata;
                REG_SEL1: regs_d.sel1     = reg_wdata;
                REG_EDGE: regs_d.edge_sel = reg_wdata;
                REG_IEN:  regs_d.ien      = reg_wdata;
                REG_FLAG: flag_wr         = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{out: RST_OUT, dir: RST_DIR, pull: RST_PULL, sel0: RST_SEL0,
                        sel1: RST_SEL1, edge_sel: '0, ien: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            REG_IN:   reg_rdata = pad_in;
            REG_OUT:  reg_rdata = regs_q.out;
            REG_DIR:  reg_rdata = regs_q.dir;
            REG_PULL: reg_rdata = regs_q.pull;
            REG_SEL0: reg_rdata = regs_q.sel0;
            REG_SEL1: reg_rdata = regs_q.sel1;
            REG_EDGE: reg_rdata = regs_q.edge_sel;
            REG_IEN:  reg_rdata = regs_q.ien;
            REG_FLAG: reg_rdata = flags;
            REG_VEC:  reg_rdata = N_PINS'(vec_code);
            default:  reg_rdata = '0;
        endcase
    end

    gpio_irq_ctrl #(
        .N_PINS (N_PINS),
        .VEC_W  (VEC_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .edge_sel (regs_q.edge_sel),
        .ien      (regs_q.ien),
        .sw_wr    (flag_wr),
        .sw_data  (reg_wdata),
        .vec_rd   (vec_rd),
        .flags    (flags),
        .vec_code (vec_code),
        .irq      (irq)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        gpio_pin_mux u_mux (
            .dir_bit   (regs_q.dir[p]),
            .out_bit   (regs_q.out[p]),
            .pull_bit  (regs_q.pull[p]),
            .fn_sel    ({regs_q.sel1[p], regs_q.sel0[p]}),
            .ser_val   (ser_out_i[p]),
            .clk_val   (clk_out_i[p]),
            .tmr_val   (tmr_out_i[p]),
            .dbg_act   (dbg_mode),
            .dbg_drive (DBG_DRIVE_MASK[p]),
            .dbg_sense (DBG_SENSE_MASK[p]),
            .dbg_val   (dbg_drive_val),
            .pad_val   (pad_in[p]),
            .pad_drv   (pad_out[p]),
            .pad_en    (pad_oe[p]),
            .pull_en   (pad_pull_en[p]),
            .pull_up   (pad_pull_up[p]),
            .cap_val   (cap_in_o[p])
        );
    end

    assign dbg_clk_o = dbg_mode ? pad_in[DBG_CLK_PIN] : 1'b1;
    assign dbg_din_o = dbg_mode ? pad_in[DBG_DIN_PIN] : 1'b1;
    assign dbg_sel_o = dbg_mode ? pad_in[DBG_SEL_PIN] : 1'b1;

    // R6: debug takeover of the four debug pins
    a_r6_dbg_takes_pins: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> (pad_oe[DBG_DOUT_PIN] && (pad_out[DBG_DOUT_PIN] == dbg_drive_val)
                      && ((pad_oe & DBG_SENSE_MASK) == '0)
                      && ((pad_pull_en & DBG_SENSE_MASK) == DBG_SENSE_MASK)
                      && ((pad_pull_up & DBG_SENSE_MASK) == DBG_SENSE_MASK)));

    // R7: idle debug inputs read high
    a_r7_dbg_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |-> (dbg_clk_o && dbg_din_o && dbg_sel_o));

    // R4: a capture input is never fed from a driven pin
    a_r4_capture_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_in_o & pad_oe) == '0);

    // R5: pull is never enabled on a driven pin
    a_r5_no_pull_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    // R2: a direction write lands in the following cycle
    a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == REG_DIR)) |=> (regs_q.dir == $past(reg_wdata)));

endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    import gpio_port_pkg::*;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [3:0]   reg_addr = 4'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [N-1:0] ser_out_i = '0;
    logic [N-1:0] clk_out_i = '0;
    logic [N-1:0] tmr_out_i = '0;
    logic [N-1:0] cap_in_o;
    logic         dbg_mode = 1'b0;
    logic         dbg_drive_val = 1'b0;
    logic         dbg_clk_o, dbg_din_o, dbg_sel_o;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_port #(.N_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .ser_out_i(ser_out_i), .clk_out_i(clk_out_i), .tmr_out_i(tmr_out_i),
        .cap_in_o(cap_in_o), .dbg_mode(dbg_mode), .dbg_drive_val(dbg_drive_val),
        .dbg_clk_o(dbg_clk_o), .dbg_din_o(dbg_din_o), .dbg_sel_o(dbg_sel_o),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input reg_addr_e a, input logic [N-1:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input reg_addr_e a, output logic [N-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_vec(output logic [N-1:0] d);
        @(negedge clk);
        reg_addr = REG_VEC;
        reg_rd   = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic set_pads(input logic [N-1:0] v);
        @(negedge clk);
        pad_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [N-1:0] d;
        rd_reg(REG_OUT, d);  check("R1 out reset", d, 32'hB0);
        rd_reg(REG_DIR, d);  check("R1 dir reset", d, 32'h00);
        rd_reg(REG_PULL, d); check("R1 pull reset", d, 32'hB0);
        rd_reg(REG_SEL0, d); check("R1 sel0 reset", d, 32'hF0);
        rd_reg(REG_SEL1, d); check("R1 sel1 reset", d, 32'hF0);
        rd_reg(REG_FLAG, d); check("R1 flag reset", d, 32'h00);
        check("R1 pads undriven", pad_oe, 32'h00);
        check("R1 pull enables", pad_pull_en, 32'hB0);
        check("R1 pull-ups", pad_pull_up, 32'hB0);
    endtask

    task automatic t_plain_io;
        logic [N-1:0] d;
        wr_reg(REG_SEL0, 8'h00);
        wr_reg(REG_SEL1, 8'h00);
        wr_reg(REG_OUT, 8'h05);
        wr_reg(REG_DIR, 8'h0F);
        #1;
        check("R2 oe for outputs", pad_oe, 32'h0F);
        check("R2 driven values", pad_out[3:0], 32'h5);
        wr_reg(REG_DIR, 8'h00);
        #1;
        check("R2 inputs undriven", pad_oe, 32'h00);
        set_pads(8'h5A);
        rd_reg(REG_IN, d); check("R11 input register", d, 32'h5A);
        set_pads(8'h00);
    endtask

    task automatic t_functions;
        wr_reg(REG_DIR, 8'h07);
        wr_reg(REG_SEL0, 8'h05);
        wr_reg(REG_SEL1, 8'h06);
        @(negedge clk);
        ser_out_i = 8'h01; clk_out_i = 8'h00; tmr_out_i = 8'h04;
        #1;
        check("R3 oe on function pins", pad_oe[2:0], 32'h7);
        check("R3 serial/clock/timer pattern A", pad_out[2:0], 32'h5);
        @(negedge clk);
        ser_out_i = 8'h00; clk_out_i = 8'h02; tmr_out_i = 8'h00;
        #1;
        check("R3 serial/clock/timer pattern B", pad_out[2:0], 32'h2);
        @(negedge clk);
        ser_out_i = '0; clk_out_i = '0; tmr_out_i = '0;
    endtask

    task automatic t_capture;
        wr_reg(REG_DIR, 8'h00);
        wr_reg(REG_SEL0, 8'h01);
        wr_reg(REG_SEL1, 8'h02);
        @(negedge clk);
        pad_in = 8'h07;
        #1;
        check("R4 capture follows pads", cap_in_o, 32'h03);
        check("R4 capture pins undriven", pad_oe, 32'h00);
        @(negedge clk);
        pad_in = 8'h00;
        #1;
        check("R4 capture low", cap_in_o, 32'h00);
    endtask

    task automatic t_pull;
        wr_reg(REG_SEL0, 8'h00);
        wr_reg(REG_SEL1, 8'h00);
        wr_reg(REG_DIR, 8'h02);
        wr_reg(REG_PULL, 8'h03);
        wr_reg(REG_OUT, 8'h01);
        #1;
        check("R5 pull only on input", pad_pull_en[1:0], 32'h1);
        check("R5 pull-up when out=1", pad_pull_up[0], 32'h1);
        wr_reg(REG_OUT, 8'h00);
        #1;
        check("R5 pull-down keeps enable", pad_pull_en[0], 32'h1);
        check("R5 pull-down when out=0", pad_pull_up[0], 32'h0);
        wr_reg(REG_PULL, 8'h00);
    endtask

    task automatic t_debug;
        @(negedge clk);
        pad_in = 8'h00;
        #1;
        check("R7 idle debug inputs high", {dbg_clk_o, dbg_din_o, dbg_sel_o}, 32'h7);
        wr_reg(REG_DIR, 8'hFF);
        wr_reg(REG_OUT, 8'h00);
        @(negedge clk);
        dbg_mode = 1'b1;
        dbg_drive_val = 1'b1;
        pad_in = 8'h20;
        #1;
        check("R6 debug pin drive", pad_oe[7:4], 32'h4);
        check("R6 debug data out", pad_out[6], 32'h1);
        check("R6 debug pulls", pad_pull_en[7:4], 32'hB);
        check("R6 debug pull-ups", pad_pull_up[7:4], 32'hB);
        check("R6 lower pins kept", pad_oe[3:0], 32'hF);
        check("R7 debug inputs follow pads", {dbg_clk_o, dbg_din_o, dbg_sel_o}, 32'h2);
        @(negedge clk);
        dbg_mode = 1'b0;
        dbg_drive_val = 1'b0;
        pad_in = 8'h00;
        #1;
        check("R6 port regains pins", pad_oe[7:4], 32'hF);
        wr_reg(REG_DIR, 8'h00);
    endtask

    task automatic t_edges;
        logic [N-1:0] d;
        set_pads(8'h00);
        wr_reg(REG_IEN, 8'h00);
        wr_reg(REG_EDGE, 8'h02);
        wr_reg(REG_FLAG, 8'h00);
        set_pads(8'h03);
        rd_reg(REG_FLAG, d); check("R8 rising sets only rising pin", d, 32'h01);
        set_pads(8'h01);
        rd_reg(REG_FLAG, d); check("R8 falling sets falling pin", d, 32'h03);
        set_pads(8'h00);
        rd_reg(REG_FLAG, d); check("R8 wrong polarity ignored", d, 32'h03);
        check("R10 no irq when disabled", irq, 32'h0);
        wr_reg(REG_FLAG, 8'h00);
        rd_reg(REG_FLAG, d); check("R12 flag write clears", d, 32'h00);
    endtask

    task automatic t_vector;
        logic [N-1:0] d;
        wr_reg(REG_EDGE, 8'h00);
        wr_reg(REG_FLAG, 8'h00);
        set_pads(8'h28);
        rd_vec(d); check("R9 vector zero when none enabled", d, 32'h00);
        rd_reg(REG_FLAG, d); check("R9 empty vector read keeps flags", d, 32'h28);
        check("R10 irq low without enable", irq, 32'h0);
        wr_reg(REG_IEN, 8'h28);
        #1;
        check("R10 irq with enable", irq, 32'h1);
        rd_vec(d); check("R9 lowest pin 3", d, 32'h08);
        rd_reg(REG_FLAG, d); check("R9 only pin 3 cleared", d, 32'h20);
        rd_vec(d); check("R9 next pin 5", d, 32'h0C);
        rd_vec(d); check("R9 vector empty", d, 32'h00);
        #1;
        check("R10 irq drops", irq, 32'h0);
        wr_reg(REG_IEN, 8'h00);
        set_pads(8'h00);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_io();
        t_functions();
        t_capture();
        t_pull();
        t_debug();
        t_edges();
        t_vector();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule